// File: doc/BRIEF.md
# Stream ID Span Filter Matcher

This block decides, for every transaction offered to it, whether that transaction's stream identifier passes the filter of each of a small set of counter slots. Each slot holds a match pattern, a span-mode bit and an enable flag. The block turns those into a per-slot match flag. A counter next to it uses the flag to gate its increment. The result is registered and appears exactly one clock after the strobe that carried the stream ID.

In exact mode every stream ID bit has to equal the corresponding pattern bit. In span mode the pattern carries its own don't-care mask. The run of ones at the bottom of the pattern is ignored, and so is the first zero bit above that run. Only the bits from that zero upward are compared. A pattern of 0x42 in span mode therefore accepts 0x42 and 0x43. A slot with filtering disabled behaves as span mode with an all-ones pattern, so it accepts every stream ID.

A build-time parameter selects one of two configurations. In the shared configuration, the settings of slot 0 govern every slot. In the per-slot configuration, each slot uses its own settings. The block has no state machine. Its only state is the registered strobe and the registered match vector.

Top module: `sidf_matcher`

## Requirements
- R1: While reset is asserted, and after it, `match_vld_o` and every bit of `match_o` are 0 until the first strobe has been registered.
- R2: `match_vld_o` is high exactly one clock after a cycle in which `sid_valid_i` was high, and low otherwise.
- R3: Whenever `match_vld_o` is low, every bit of `match_o` is 0.
- R4: With a slot enabled and its span bit at 0, that slot's `match_o` bit is 1 only if all SID_W stream ID bits equal the slot's pattern bits.
- R5: With a slot enabled and its span bit at 1, let Y-1 be the position of the lowest 0 bit of the slot's pattern. Bits Y-1 and below are ignored, and the slot matches if and only if stream ID bits Y and above equal the pattern's bits Y and above.
- R6: In span mode, pattern 0x42 matches stream IDs 0x42 and 0x43 and rejects 0x40 and 0x44.
- R7: In span mode, an all-ones pattern matches every stream ID.
- R8: A slot whose enable bit is 0 matches every stream ID, whatever its pattern and span bit hold.
- R9: With GLOBAL_CFG=1, the enable, pattern and span of slot 0 (pattern bits [SID_W-1:0], span bit 0, enable bit 0) decide every slot's match bit, and the settings of the other slots have no effect.
- R10: With GLOBAL_CFG=0, slot k uses its own pattern `cfg_pattern_i[k*SID_W +: SID_W]`, its own span bit `cfg_span_i[k]` and its own enable bit `cfg_en_i[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pattern_i | input | NUM_SLOTS*SID_W | Match patterns; slot k occupies bits [k*SID_W +: SID_W] |
| cfg_span_i | input | NUM_SLOTS | Per-slot span mode: 0 exact, 1 pattern |
| cfg_en_i | input | NUM_SLOTS | Per-slot filter enable: 0 accepts every stream ID |
| sid_i | input | SID_W | Stream ID of the offered transaction |
| sid_valid_i | input | 1 | Strobe qualifying `sid_i` |
| match_vld_o | output | 1 | Registered strobe, one clock after `sid_valid_i` |
| match_o | output | NUM_SLOTS | Registered per-slot match flags |

## Verification
A wrong don't-care mask shows at the ports on the clock after the first strobe whose stream ID differs from the pattern only in the bits near the pattern's lowest zero. The match flag for that slot is then the inverse of the expected value. That is why the bench sweeps every pattern against every stream ID at a narrow width, in both modes. A mix-up in the slot routing shows on the same clock as a slot that disagrees with its own settings, or with slot 0's settings in the shared configuration. A broken strobe register shows as `match_vld_o` shifted by one cycle against every strobe.

// File: rtl/sidf_pkg.sv
package sidf_pkg;

    // Comparison mode of a slot after the enable default has been applied.
    typedef enum logic {
        MODE_EXACT = 1'b0,
        MODE_SPAN  = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/sidf_settings_sel.sv
module sidf_settings_sel #(
    parameter int SID_W      = 32,
    parameter int NUM_SLOTS  = 2,
    parameter bit GLOBAL_CFG = 1'b0
) (
    input  logic [NUM_SLOTS*SID_W-1:0]          pattern_i,
    input  logic [NUM_SLOTS-1:0]                span_i,
    input  logic [NUM_SLOTS-1:0]                en_i,
    output logic [NUM_SLOTS-1:0][SID_W-1:0]     eff_pattern_o,
    output sidf_pkg::cmp_mode_e [NUM_SLOTS-1:0] eff_mode_o
);
    import sidf_pkg::*;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic             src_en;
        logic [SID_W-1:0] src_pat;
        logic             src_span;

        if (GLOBAL_CFG) begin : g_shared
            assign src_en   = en_i[0];
            assign src_pat  = pattern_i[SID_W-1:0];
            assign src_span = span_i[0];
        end else begin : g_own
            assign src_en   = en_i[g];
            assign src_pat  = pattern_i[g*SID_W +: SID_W];
            assign src_span = span_i[g];
        end

        // A disabled filter acts as span mode with an all-ones pattern.
        assign eff_pattern_o[g] = src_en ? src_pat : {SID_W{1'b1}};
        assign eff_mode_o[g]    = (src_en && !src_span) ? MODE_EXACT : MODE_SPAN;
    end

endmodule

// File: rtl/sidf_care_mask.sv
module sidf_care_mask #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0]  pattern_i,
    input  sidf_pkg::cmp_mode_e mode_i,
    output logic [SID_W-1:0]  care_o
);
    import sidf_pkg::*;

    logic [SID_W-1:0] pat_inc;
    logic [SID_W-1:0] dont_care;

    // Incrementing flips the trailing ones and the first zero; the carry out of
    // an all-ones pattern is dropped, which leaves a full don't-care mask.
    assign pat_inc   = pattern_i + SID_W'(1);
    assign dont_care = pattern_i ^ pat_inc;

    always_comb begin
        unique case (mode_i)
            MODE_EXACT: care_o = {SID_W{1'b1}};
            MODE_SPAN:  care_o = ~dont_care;
            default:    care_o = {SID_W{1'b1}};
        endcase
    end

endmodule

// File: rtl/sidf_slot_cmp.sv
module sidf_slot_cmp #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] sid_i,
    input  logic [SID_W-1:0] pattern_i,
    input  logic [SID_W-1:0] care_i,
    output logic             hit_o
);
    logic [SID_W-1:0] diff;

    assign diff  = (sid_i ^ pattern_i) & care_i;
    assign hit_o = (diff == '0);

endmodule

// File: rtl/sidf_matcher.sv
module sidf_matcher #(
    parameter int SID_W      = 32,
    parameter int NUM_SLOTS  = 2,
    parameter bit GLOBAL_CFG = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS*SID_W-1:0] cfg_pattern_i,
    input  logic [NUM_SLOTS-1:0]       cfg_span_i,
    input  logic [NUM_SLOTS-1:0]       cfg_en_i,
    input  logic [SID_W-1:0]           sid_i,
    input  logic                       sid_valid_i,
    output logic                       match_vld_o,
    output logic [NUM_SLOTS-1:0]       match_o
);
    import sidf_pkg::*;

    logic [NUM_SLOTS-1:0][SID_W-1:0] eff_pattern;
    cmp_mode_e [NUM_SLOTS-1:0]       eff_mode;
    logic [NUM_SLOTS-1:0]            slot_hit;
    logic                            vld_q;
    logic [NUM_SLOTS-1:0]            match_q;

    sidf_settings_sel #(
        .SID_W      (SID_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .GLOBAL_CFG (GLOBAL_CFG)
    ) u_sel (
        .pattern_i     (cfg_pattern_i),
        .span_i        (cfg_span_i),
        .en_i          (cfg_en_i),
        .eff_pattern_o (eff_pattern),
        .eff_mode_o    (eff_mode)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        logic [SID_W-1:0] care;

        sidf_care_mask #(.SID_W(SID_W)) u_mask (
            .pattern_i (eff_pattern[g]),
            .mode_i    (eff_mode[g]),
            .care_o    (care)
        );

        sidf_slot_cmp #(.SID_W(SID_W)) u_cmp (
            .sid_i     (sid_i),
            .pattern_i (eff_pattern[g]),
            .care_i    (care),
            .hit_o     (slot_hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            match_q <= '0;
        end else begin
            vld_q   <= sid_valid_i;
            match_q <= sid_valid_i ? slot_hit : '0;
        end
    end

    assign match_vld_o = vld_q;
    assign match_o     = match_q;

endmodule

// File: rtl/sidf_matcher_chk.sv
module sidf_matcher_chk #(
    parameter int SID_W      = 32,
    parameter int NUM_SLOTS  = 2,
    parameter bit GLOBAL_CFG = 1'b0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SLOTS*SID_W-1:0] cfg_pattern_i,
    input logic [NUM_SLOTS-1:0]       cfg_span_i,
    input logic [NUM_SLOTS-1:0]       cfg_en_i,
    input logic [SID_W-1:0]           sid_i,
    input logic                       sid_valid_i,
    input logic                       match_vld_o,
    input logic [NUM_SLOTS-1:0]       match_o
);

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (match_vld_o == $past(sid_valid_i)));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld_o |-> (match_o == '0));

    // R4
    exact_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && match_vld_o && $past(cfg_en_i[0] && !cfg_span_i[0]))
        |-> (match_o[0] == $past(sid_i == cfg_pattern_i[SID_W-1:0])));

    // R7
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && match_vld_o &&
         $past(cfg_en_i[0] && cfg_span_i[0] && (&cfg_pattern_i[SID_W-1:0])))
        |-> match_o[0]);

    // R8
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && match_vld_o && $past(!cfg_en_i[0])) |-> match_o[0]);

    if (GLOBAL_CFG) begin : g_shared_chk
        // R9
        shared_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
            match_vld_o |-> ((match_o == '0) || (&match_o)));
    end

endmodule

bind sidf_matcher sidf_matcher_chk #(
    .SID_W      (SID_W),
    .NUM_SLOTS  (NUM_SLOTS),
    .GLOBAL_CFG (GLOBAL_CFG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_pattern_i (cfg_pattern_i),
    .cfg_span_i    (cfg_span_i),
    .cfg_en_i      (cfg_en_i),
    .sid_i         (sid_i),
    .sid_valid_i   (sid_valid_i),
    .match_vld_o   (match_vld_o),
    .match_o       (match_o)
);

// File: tb/test_sidf_matcher.sv
module test_sidf_matcher;
    localparam int W = 7;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] cfg_pattern = '0;
    logic [N-1:0]   cfg_span = '0;
    logic [N-1:0]   cfg_en = '0;
    logic [W-1:0]   sid = '0;
    logic           sid_valid = 1'b0;
    logic           vld_own, vld_glb;
    logic [N-1:0]   m_own, m_glb;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    sidf_matcher #(.SID_W(W), .NUM_SLOTS(N), .GLOBAL_CFG(1'b0)) i_sidf_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_pattern_i(cfg_pattern), .cfg_span_i(cfg_span),
        .cfg_en_i(cfg_en), .sid_i(sid), .sid_valid_i(sid_valid),
        .match_vld_o(vld_own), .match_o(m_own));

    sidf_matcher #(.SID_W(W), .NUM_SLOTS(N), .GLOBAL_CFG(1'b1)) i_sidf_matcher_glb (
        .clk(clk), .rst_n(rst_n), .cfg_pattern_i(cfg_pattern), .cfg_span_i(cfg_span),
        .cfg_en_i(cfg_en), .sid_i(sid), .sid_valid_i(sid_valid),
        .match_vld_o(vld_glb), .match_o(m_glb));

    function automatic bit exp_hit(input logic [W-1:0] pat, input bit span,
                                   input bit en, input logic [W-1:0] id);
        int  y;
        bit  found;
        bit  ok;
        if (!en) return 1'b1;
        if (!span) return (pat == id);
        y = W;
        found = 1'b0;
        for (int b = 0; b < W; b++) begin
            if (!found && !pat[b]) begin
                y = b + 1;
                found = 1'b1;
            end
        end
        ok = 1'b1;
        for (int b = 0; b < W; b++)
            if (b >= y && pat[b] != id[b]) ok = 1'b0;
        return ok;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (sid %0h pat %0h span %0b en %0b)",
                     req, act, exp, sid, cfg_pattern, cfg_span, cfg_en);
        end
    endtask

    // Drive one strobe at a falling edge; results are registered at the next
    // rising edge and sampled at the falling edge after it.
    task automatic strobe(input logic [W-1:0] id);
        @(negedge clk);
        sid = id;
        sid_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        bit e0, e1, eg;
        e0 = exp_hit(cfg_pattern[W-1:0], cfg_span[0], cfg_en[0], sid);
        e1 = exp_hit(cfg_pattern[2*W-1:W], cfg_span[1], cfg_en[1], sid);
        eg = e0;
        chk(vld_own == 1'b1, "R2", int'(vld_own), 1);
        chk(m_own[0] == e0, req, int'(m_own[0]), int'(e0));
        chk(m_own[1] == e1, "R10", int'(m_own[1]), int'(e1));
        chk(m_glb == {eg, eg}, "R9", int'(m_glb), int'({eg, eg}));
    endtask

    initial begin : watchdog
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        chk(vld_own == 1'b0 && m_own == '0, "R1", int'({vld_own, m_own}), 0);
        chk(vld_glb == 1'b0 && m_glb == '0, "R1", int'({vld_glb, m_glb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still idle after reset release with no strobe
        chk(vld_own == 1'b0 && m_own == '0, "R1", int'({vld_own, m_own}), 0);

        // Exhaustive sweep: slot 0 every pattern, slot 1 a different setting.
        cfg_en = 2'b11;
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < (1 << W); p++) begin
                cfg_pattern = {W'(~p), W'(p)};
                cfg_span    = {1'(~s), 1'(s)};
                for (int id = 0; id < (1 << W); id++) begin
                    strobe(W'(id));
                    if (s == 0)                       check_all("R4");
                    else if (p == (1 << W) - 1)       check_all("R7");
                    else                              check_all("R5");
                end
            end
        end

        // R6: the worked example
        cfg_pattern = {W'(0), W'(7'h42)};
        cfg_span = 2'b01;
        strobe(W'(7'h42)); chk(m_own[0] == 1'b1, "R6", int'(m_own[0]), 1);
        strobe(W'(7'h43)); chk(m_own[0] == 1'b1, "R6", int'(m_own[0]), 1);
        strobe(W'(7'h40)); chk(m_own[0] == 1'b0, "R6", int'(m_own[0]), 0);
        strobe(W'(7'h44)); chk(m_own[0] == 1'b0, "R6", int'(m_own[0]), 0);

        // R3: no strobe, outputs quiet on the following cycle
        @(negedge clk);
        sid_valid = 1'b0;
        sid = W'(7'h42);
        @(negedge clk);
        chk(vld_own == 1'b0 && m_own == '0, "R3", int'({vld_own, m_own}), 0);
        chk(vld_glb == 1'b0 && m_glb == '0, "R3", int'({vld_glb, m_glb}), 0);

        // R8: disabled slot 0 with a pattern that would otherwise reject
        cfg_en = 2'b10;
        for (int s = 0; s < 2; s++) begin
            cfg_span = {1'b0, 1'(s)};
            cfg_pattern = {W'(7'h15), W'(7'h00)};
            for (int id = 1; id < (1 << W); id += 9) begin
                strobe(W'(id));
                chk(m_own[0] == 1'b1, "R8", int'(m_own[0]), 1);
                check_all("R8");
            end
        end

        // R9: slot 0 enabled and rejecting, slot 1 disabled; shared build rejects all
        cfg_en = 2'b01;
        cfg_span = 2'b00;
        cfg_pattern = {W'(7'h11), W'(7'h22)};
        strobe(W'(7'h11));
        chk(m_glb == 2'b00, "R9", int'(m_glb), 0);
        chk(m_own == 2'b10, "R10", int'(m_own), 2);

        @(negedge clk);
        sid_valid = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule